// File: doc/BRIEF.md
# Overlapping Serial Pattern Detector

The block reads one serial bit on every clock and looks for the four-bit pattern 0, 1, 0, 1, in order of arrival. When the bit arriving now completes that pattern, the detect output goes high in the same cycle. The output is a Mealy output: it depends on the held progress and on the live input bit, so it needs no extra register. Matches may overlap. The closing "01" of one match can serve as the opening "01" of the next, so the stream 01010100 gives 00010100.

Progress through the pattern is held in a two-bit state register. The encoding is fixed: idle = 00, "0" seen = 01, "01" seen = 10, "010" seen = 11. No two of these four states are equivalent, so the count cannot be reduced. A control module owns the state register. It passes a small strobe struct to a datapath module, which forms the detect bit. A thin top joins the two.

Top module: `overlap_seq_detector`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state returns to idle. While `rst` is high, `detect` is 0 whatever `dataIn` is. No bit presented before or during reset can count toward a later match.
- R2: `detect` is 1 exactly when the current `dataIn` is 1 and the three bits clocked in since reset just before it were 0, 1, 0, oldest first.
- R3: Detection overlaps. Starting from reset, the input 0,1,0,1,0,1,0,0 gives the output 0,0,0,1,0,1,0,0.
- R4: After a match, the machine is in the "01 seen" state. A following 0 and then 1 complete a second match.
- R5: In the "0 seen" state, a 0 input keeps the machine in "0 seen". A run of zeros ending in 1,0,1 still gives a match.
- R6: In the "010 seen" state, a 0 input returns the machine to "0 seen". So 0,1,0,0,1,0,1 matches only on its last bit.
- R7: In the "01 seen" state, a 1 input returns the machine to idle. So 0,1,1,0,1,0,1 matches only on its last bit, and 0,1,1,1 never matches.
- R8: In the "010 seen" state, `detect` follows `dataIn` within the cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 1 | Serial data bit, one per clock |
| detect | output | 1 | High while the current bit completes 0101 |

## Verification
The bench goes after the three fallback paths and the overlap path.
- A design that returns to idle after a match, instead of to "01 seen", misses the second 1 in 01010100.
- A design that sends a zero in "010 seen" to idle misses the match at the end of 0100101.
- A design that sends a one in "01 seen" anywhere but idle reports a false match in 0111-style streams.

It also toggles the input inside one cycle while the machine sits in "010 seen". A registered output fails this check, and so does one that ignores the live bit. It further checks that a reset applied partway through a pattern discards the partial progress. Finally, a long pseudo-random stream is compared against the behavioural model on every clock.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  localparam int STATE_W = 2;

  // Binary state assignment, two flip-flops.
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE   = 2'b00,
    ST_ZERO   = 2'b01,
    ST_ZO     = 2'b10,
    ST_ZOZ    = 2'b11
  } seqState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic armed;    // three leading pattern bits held
    logic holdOff;  // reset active, force output low
  } ctrlStrobe_t;

endpackage

// File: rtl/seqdet_ctrl.sv
module seqdet_ctrl
  import seqdet_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        dataIn,
  output seqState_t   curState,
  output ctrlStrobe_t strobes
);

  seqState_t nextState;

  always_comb begin
    nextState = curState;
    unique case (curState)
      ST_IDLE: nextState = dataIn ? ST_IDLE : ST_ZERO;
      ST_ZERO: nextState = dataIn ? ST_ZO   : ST_ZERO;
      ST_ZO:   nextState = dataIn ? ST_IDLE : ST_ZOZ;
      ST_ZOZ:  nextState = dataIn ? ST_ZO   : ST_ZERO;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_IDLE;
    else     curState <= nextState;
  end

  always_comb begin
    strobes.armed   = (curState == ST_ZOZ);
    strobes.holdOff = rst;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> curState == ST_IDLE);

  // R4
  match_to_zo_chk: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_ZOZ && dataIn) |=> curState == ST_ZO);

  // R5
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_ZERO && !dataIn) |=> curState == ST_ZERO);

  // R6
  zoz_fallback_chk: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_ZOZ && !dataIn) |=> curState == ST_ZERO);

  // R7
  zo_fallback_chk: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_ZO && dataIn) |=> curState == ST_IDLE);

endmodule

// File: rtl/seqdet_datapath.sv
module seqdet_datapath
  import seqdet_pkg::*;
(
  input  logic        dataIn,
  input  ctrlStrobe_t strobes,
  output logic        detect
);

  always_comb begin
    detect = strobes.armed & dataIn & ~strobes.holdOff;
  end

  // R1
  always_comb begin
    if (strobes.holdOff) begin
      hold_low_chk: assert (!detect);
    end
  end

endmodule

// File: rtl/overlap_seq_detector.sv
module overlap_seq_detector
  import seqdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dataIn,
  output logic detect
);

  seqState_t   ctrlState;
  ctrlStrobe_t ctrlStrobes;

  seqdet_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .dataIn   (dataIn),
    .curState (ctrlState),
    .strobes  (ctrlStrobes)
  );

  seqdet_datapath u_dp (
    .dataIn  (dataIn),
    .strobes (ctrlStrobes),
    .detect  (detect)
  );

  // R2
  detect_origin_chk: assert property (@(posedge clk) disable iff (rst)
    detect |-> (ctrlState == ST_ZOZ && dataIn));

  // R2
  detect_prior_chk: assert property (@(posedge clk) disable iff (rst)
    detect |-> ($past(ctrlState) == ST_ZO && !$past(dataIn)));

endmodule

// File: tb/overlap_seq_detector_test.sv
module overlap_seq_detector_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dataIn = 1'b0;
  logic detect;

  int vecCount = 0;
  int errCount = 0;
  bit hist[$];
  bit doneFlag = 1'b0;

  overlap_seq_detector uut (
    .clk    (clk),
    .rst    (rst),
    .dataIn (dataIn),
    .detect (detect)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic bit modelOut(bit b);
    int n = hist.size();
    if (n < 3) return 1'b0;
    return (hist[n-3] == 1'b0) && (hist[n-2] == 1'b1) && (hist[n-1] == 1'b0) && b;
  endfunction

  task automatic check(string req, logic got, logic exp);
    vecCount++;
    if (got !== exp) begin
      errCount++;
      $display("FAIL %s: detect=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic sendBit(bit b, string req);
    @(negedge clk);
    dataIn = b;
    #5;
    check(req, detect, modelOut(b));
    @(posedge clk);
    hist.push_back(b);
    if (hist.size() > 4) void'(hist.pop_front());
  endtask

  task automatic sendStream(string bits, string req);
    foreach (bits[i]) sendBit(bits[i] == "1", req);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    dataIn = 1'b1;
    #5;
    check("R1 reset low", detect, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    hist.delete();
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errCount++;
    $display("FAIL watchdog: detect=%b expected=done", detect);
    finishRun();
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #5;
    check("R1 during reset", detect, 1'b0);
    rst = 1'b0;
    hist.delete();

    // R3 overlap stream
    sendStream("01010100", "R3");
    doReset();
    // R4 repeated matches after a hit
    sendStream("0101010101", "R4");
    doReset();
    // R5 zero run
    sendStream("0000101", "R5");
    doReset();
    // R6 fallback from 010 on zero
    sendStream("0100101", "R6");
    doReset();
    // R7 fallback from 01 on one
    sendStream("0110101", "R7");
    sendStream("0111", "R7");
    doReset();

    // R1 reset mid-pattern discards progress
    sendStream("010", "R1");
    doReset();
    sendStream("1", "R1");
    sendStream("0101", "R1");

    // R8 Mealy output follows input within the cycle
    doReset();
    sendStream("010", "R8");
    @(negedge clk);
    dataIn = 1'b1;
    #3;
    check("R8 live high", detect, 1'b1);
    dataIn = 1'b0;
    #3;
    check("R8 live low", detect, 1'b0);
    dataIn = 1'b1;
    #2;
    check("R8 live high again", detect, 1'b1);
    @(posedge clk);
    hist.push_back(1'b1);
    if (hist.size() > 4) void'(hist.pop_front());

    // R2 pseudo-random stream vs model
    doReset();
    lfsr = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      sendBit(lfsr[0], "R2");
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end

    finishRun();
  end

endmodule